// File: doc/BRIEF.md
# Maskable Event Interrupt Accumulator

This block gathers single-cycle event pulses into an 8-bit pending register. An 8-bit enable mask selects which pending bits may raise an active-low interrupt line toward the host. Two of the pending bits belong to a peripheral bus:

- the reply-waiting bit, set when a reply from that bus has been stored;
- the auto-poll bit, set in addition when the reply came from automatic polling.

A periodic tick occupies another bit. Any bit can also be set directly through the event input.

The host drives two command strobes, each with an argument count:

- **Set-mask** loads a new mask.
- **Acknowledge** reads the pending state and clears it, and the response leaves as a byte stream. When a bus reply is waiting, the response is a header holding only the two bus bits, followed by the stored reply bytes, and only those two bits are cleared. Otherwise the response is the whole pending byte and every bit is cleared.

A malformed command is dropped without effect. The polling engine that produces replies sits outside the block and only presents finished replies on a load port.

Top module: `evt_irq_accum`

## Requirements
- R1: After reset the pending register is 0x00 and the mask is 0x11, which enables only the tick bit (bit 0) and the reply-waiting bit (bit 4). `irq_n` is high, no response byte is valid, and an acknowledge returns the single byte 0x00.
- R2: `irq_n` is low exactly when (pending AND mask) is nonzero. It reflects each set, clear or mask write from the cycle after the clock edge that applied it.
- R3: A set-mask strobe with an argument count of exactly 1 loads `cmd_arg` into the mask. With any other count the mask keeps its value.
- R4: An acknowledge strobe with a nonzero argument count produces no response and leaves the pending bits unchanged.
- R5: An acknowledge with bit 4 clear returns one byte equal to the pending register and clears all pending bits.
- R6: An acknowledge with bit 4 set returns a header byte equal to pending AND 0x30, followed by the stored reply bytes. It clears only bits 4 and 5 and empties the stored reply.
- R7: An auto-poll load (`rpl_load` with `rpl_auto`) sets bits 4 and 5 and stores `rpl_len` bytes, byte i taken from `rpl_data[8*i+7:8*i]`. It is ignored entirely while bit 4 is already pending.
- R8: A non-auto reply load sets only bit 4 and always replaces the stored reply.
- R9: If a bit is set, by `evt_set` or by a load, in the same cycle that an acknowledge clears it, the bit stays pending.
- R10: An acknowledge strobe that arrives while a response is still streaming is ignored.
- R11: Response bytes appear on consecutive cycles, starting the cycle after the acknowledge strobe. `rsp_last` is high on the final byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set | input | 8 | Per-bit event pulses into the pending register |
| rpl_load | input | 1 | Store a finished bus reply |
| rpl_auto | input | 1 | The reply being loaded came from auto-polling |
| rpl_len | input | LEN_W | Number of reply bytes |
| rpl_data | input | RPL_MAX*8 | Reply bytes, first byte in the low 8 bits |
| cmd_mask_stb | input | 1 | Set-mask command strobe |
| cmd_ack_stb | input | 1 | Acknowledge command strobe |
| cmd_argc | input | ARGC_W | Argument count of the strobed command |
| cmd_arg | input | 8 | First argument byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |
| irq_n | output | 1 | Interrupt line, low when an enabled bit is pending |

## Verification
The bench checks the split in acknowledge behaviour in both directions. A design that always cleared the full register would lose a tick that was pending alongside a reply, and one that never emptied the stored reply would repeat stale bytes after a bare bit-4 event. It sends a second auto-poll while bit 4 is set, where a faulty design would overwrite the first reply. It also sends argument-count errors on both commands, which a lax decoder would act on. It collides an event with the clearing acknowledge, where the wrong priority silently drops the event. Finally it sends a second acknowledge during streaming, which would corrupt the byte sequence if it were accepted.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // pending update: sets take priority over clears
  function automatic byte_t f_next_pend(byte_t cur, byte_t clr, byte_t set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic f_irq_active(byte_t pend, byte_t mask);
    return |(pend & mask);
  endfunction

  function automatic byte_t f_ack_header(byte_t pend, byte_t bus_bits, logic bus_hit);
    return bus_hit ? (pend & bus_bits) : pend;
  endfunction

  function automatic byte_t f_ack_clear(byte_t bus_bits, logic bus_hit);
    return bus_hit ? bus_bits : '1;
  endfunction
endpackage

// File: rtl/evt_pending_reg.sv
module evt_pending_reg #(
  parameter evt_pkg::byte_t MASK_RST = 8'h11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  evt_pkg::byte_t set_bits,
  input  evt_pkg::byte_t clr_bits,
  input  logic           mask_we,
  input  evt_pkg::byte_t mask_din,
  output evt_pkg::byte_t pend_q,
  output evt_pkg::byte_t mask_q,
  output logic           irq_n
);
  import evt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= f_next_pend(pend_q, clr_bits, set_bits);
      if (mask_we) mask_q <= mask_din;
    end
  end

  assign irq_n = ~f_irq_active(pend_q, mask_q);
endmodule

// File: rtl/evt_reply_store.sv
module evt_reply_store #(
  parameter int RPL_MAX = 8,
  parameter int LEN_W   = $clog2(RPL_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [LEN_W-1:0]      load_len,
  input  logic [RPL_MAX*8-1:0]  load_data,
  input  logic                  drop,
  output logic [LEN_W-1:0]      len_q,
  output logic [RPL_MAX*8-1:0]  data_q
);
  function automatic logic [LEN_W-1:0] f_clamp(logic [LEN_W-1:0] n);
    return (n > LEN_W'(RPL_MAX)) ? LEN_W'(RPL_MAX) : n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      len_q  <= f_clamp(load_len);
      data_q <= load_data;
    end else if (drop) begin
      len_q  <= '0;
    end
  end
endmodule

// File: rtl/evt_rsp_stream.sv
module evt_rsp_stream #(
  parameter int RPL_MAX = 8,
  parameter int LEN_W   = $clog2(RPL_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  evt_pkg::byte_t        hdr,
  input  logic                  with_reply,
  input  logic [LEN_W-1:0]      rpl_len,
  input  logic [RPL_MAX*8-1:0]  rpl_data,
  output logic                  busy,
  output logic                  rsp_valid,
  output evt_pkg::byte_t        rsp_data,
  output logic                  rsp_last
);
  import evt_pkg::*;
  localparam int BUF_W = (RPL_MAX + 1) * BYTE_W;
  localparam int CNT_W = $clog2(RPL_MAX + 2);

  logic [BUF_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      buf_q <= {rpl_data, hdr};
      cnt_q <= with_reply ? (CNT_W'(rpl_len) + CNT_W'(1)) : CNT_W'(1);
    end else if (cnt_q != '0) begin
      buf_q <= buf_q >> BYTE_W;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy      = (cnt_q != '0);
  assign rsp_valid = busy;
  assign rsp_data  = buf_q[BYTE_W-1:0];
  assign rsp_last  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/evt_irq_accum.sv
module evt_irq_accum #(
  parameter int RPL_MAX  = 8,
  parameter int ARGC_W   = 4,
  parameter int TICK_BIT = 0,
  parameter int BUS_BIT  = 4,
  parameter int AUTO_BIT = 5,
  localparam int LEN_W   = $clog2(RPL_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           evt_set,
  input  logic                 rpl_load,
  input  logic                 rpl_auto,
  input  logic [LEN_W-1:0]     rpl_len,
  input  logic [RPL_MAX*8-1:0] rpl_data,
  input  logic                 cmd_mask_stb,
  input  logic                 cmd_ack_stb,
  input  logic [ARGC_W-1:0]    cmd_argc,
  input  logic [7:0]           cmd_arg,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_data,
  output logic                 rsp_last,
  output logic                 irq_n
);
  import evt_pkg::*;

  localparam byte_t BUS_ONE  = byte_t'(1) << BUS_BIT;
  localparam byte_t AUTO_ONE = byte_t'(1) << AUTO_BIT;
  localparam byte_t TICK_ONE = byte_t'(1) << TICK_BIT;
  localparam byte_t BUS_BITS = BUS_ONE | AUTO_ONE;
  localparam byte_t MASK_RST = BUS_ONE | TICK_ONE;

  byte_t pend_q, mask_q, set_bits, clr_bits, hdr;
  logic  bus_hit, ack_ok, mask_ok, load_ok, auto_ok, stream_busy;
  logic [LEN_W-1:0]     st_len;
  logic [RPL_MAX*8-1:0] st_data;

  // command and event decode
  assign bus_hit  = pend_q[BUS_BIT];
  assign ack_ok   = cmd_ack_stb && (cmd_argc == '0) && !stream_busy;
  assign mask_ok  = cmd_mask_stb && (cmd_argc == ARGC_W'(1));
  assign load_ok  = rpl_load && !(rpl_auto && bus_hit);
  assign auto_ok  = load_ok && rpl_auto;
  assign set_bits = evt_set
                  | (load_ok ? BUS_ONE : '0)
                  | (auto_ok ? AUTO_ONE : '0);
  assign clr_bits = ack_ok ? f_ack_clear(BUS_BITS, bus_hit) : '0;
  assign hdr      = f_ack_header(pend_q, BUS_BITS, bus_hit);

  evt_pending_reg #(.MASK_RST(MASK_RST)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .mask_we  (mask_ok),
    .mask_din (cmd_arg),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .irq_n    (irq_n)
  );

  evt_reply_store #(.RPL_MAX(RPL_MAX), .LEN_W(LEN_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ok),
    .load_len  (rpl_len),
    .load_data (rpl_data),
    .drop      (ack_ok && bus_hit),
    .len_q     (st_len),
    .data_q    (st_data)
  );

  evt_rsp_stream #(.RPL_MAX(RPL_MAX), .LEN_W(LEN_W)) u_stream (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ack_ok),
    .hdr        (hdr),
    .with_reply (bus_hit),
    .rpl_len    (st_len),
    .rpl_data   (st_data),
    .busy       (stream_busy),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_last   (rsp_last)
  );
endmodule

// File: rtl/evt_irq_accum_chk.sv
module evt_irq_accum_chk #(
  parameter int ARGC_W   = 4,
  parameter int BUS_BIT  = 4,
  parameter int AUTO_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        evt_set,
  input logic              cmd_ack_stb,
  input logic              cmd_mask_stb,
  input logic [ARGC_W-1:0] cmd_argc,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic              irq_n,
  input logic [7:0]        pend_q,
  input logic [7:0]        mask_q,
  input logic              auto_ok
);
  AST_IRQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pend_q) && $stable(mask_q)) |-> $stable(irq_n)); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_mask_stb && cmd_argc == ARGC_W'(1)) |=> $stable(mask_q)); // R3

  AST_ACK_ARG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack_stb && cmd_argc != '0 && !rsp_valid) |=> !rsp_valid); // R4

  AST_AUTO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    auto_ok |=> (pend_q[BUS_BIT] && pend_q[AUTO_BIT])); // R7

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((pend_q & $past(evt_set)) == $past(evt_set))); // R9

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> rsp_valid); // R10

  AST_ACK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack_stb && cmd_argc == '0 && !rsp_valid) |=> rsp_valid); // R11

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid); // R11
endmodule

bind evt_irq_accum evt_irq_accum_chk #(
  .ARGC_W(ARGC_W), .BUS_BIT(BUS_BIT), .AUTO_BIT(AUTO_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_set      (evt_set),
  .cmd_ack_stb  (cmd_ack_stb),
  .cmd_mask_stb (cmd_mask_stb),
  .cmd_argc     (cmd_argc),
  .rsp_valid    (rsp_valid),
  .rsp_last     (rsp_last),
  .irq_n        (irq_n),
  .pend_q       (pend_q),
  .mask_q       (mask_q),
  .auto_ok      (auto_ok)
);

// File: tb/sim_evt_irq_accum.sv
module sim_evt_irq_accum;
  localparam int CLK_PER = 10;
  localparam int RMAX    = 8;
  localparam int LW      = $clog2(RMAX + 1);

  logic clk = 0, rst_n = 0;
  logic [7:0] evt_set = 0;
  logic rpl_load = 0, rpl_auto = 0;
  logic [LW-1:0] rpl_len = 0;
  logic [RMAX*8-1:0] rpl_data = 0;
  logic cmd_mask_stb = 0, cmd_ack_stb = 0;
  logic [3:0] cmd_argc = 0;
  logic [7:0] cmd_arg = 0;
  logic rsp_valid, rsp_last, irq_n;
  logic [7:0] rsp_data;

  always #(CLK_PER/2) clk = ~clk;

  evt_irq_accum u0 (.*);

  int nchk = 0, nerr = 0, nlast = 0;
  bit done = 0;
  logic [7:0] m_pend, m_mask;
  logic [7:0] m_rpl[$];
  logic [7:0] m_out[$];
  logic [7:0] got[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, applied at each rising edge
  task automatic model_edge();
    bit busy, ackok, busp, loadok;
    logic [7:0] clr, set, hdr;
    busy = (m_out.size() > 0);
    if (busy) void'(m_out.pop_front());
    busp  = m_pend[4];
    ackok = cmd_ack_stb && cmd_argc == 0 && !busy;
    loadok = rpl_load && !(rpl_auto && busp);
    clr = 0;
    if (ackok) begin
      hdr = busp ? (m_pend & 8'h30) : m_pend;
      m_out.push_back(hdr);
      if (busp) begin
        foreach (m_rpl[i]) m_out.push_back(m_rpl[i]);
        m_rpl.delete();
        clr = 8'h30;
      end else clr = 8'hff;
    end
    set = evt_set;
    if (loadok) begin
      set = set | 8'h10 | (rpl_auto ? 8'h20 : 8'h00);
      m_rpl.delete();
      for (int i = 0; i < int'(rpl_len); i++) m_rpl.push_back(rpl_data[8*i +: 8]);
    end
    m_pend = (m_pend & ~clr) | set;
    if (cmd_mask_stb && cmd_argc == 1) m_mask = cmd_arg;
  endtask

  task automatic compare();
    logic exp_irq;
    exp_irq = ((m_pend & m_mask) == 0);
    chk(irq_n === exp_irq, "R2 irq_n", irq_n, exp_irq);
    chk(rsp_valid === (m_out.size() > 0), "R11 rsp_valid", rsp_valid, m_out.size() > 0);
    if (m_out.size() > 0) begin
      chk(rsp_data === m_out[0], "R11 rsp_data", rsp_data, m_out[0]);
      chk(rsp_last === (m_out.size() == 1), "R11 rsp_last", rsp_last, m_out.size() == 1);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    evt_set = 0; rpl_load = 0; rpl_auto = 0; cmd_mask_stb = 0; cmd_ack_stb = 0;
    cmd_argc = 0; cmd_arg = 0;
  endtask

  task automatic ack_collect(input logic [7:0] evt);
    int guard;
    cmd_ack_stb = 1; cmd_argc = 0; evt_set = evt;
    step();
    got.delete();
    nlast = 0;
    guard = 0;
    while (rsp_valid && guard < 20) begin
      got.push_back(rsp_data);
      if (rsp_last) nlast++;
      step();
      guard++;
    end
  endtask

  task automatic chk_seq(input string tag, input logic [7:0] e[$]);
    chk(got.size() == e.size(), {tag, " length"}, got.size(), e.size());
    for (int i = 0; i < e.size() && i < got.size(); i++)
      chk(got[i] === e[i], {tag, " byte"}, got[i], e[i]);
  endtask

  task automatic load(input bit au, input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    rpl_load = 1; rpl_auto = au; rpl_len = LW'(n);
    rpl_data = '0;
    rpl_data[7:0] = b0; rpl_data[15:8] = b1; rpl_data[23:16] = b2;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_mask = 8'h11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    ack_collect(0);
    chk_seq("R1 empty ack", '{8'h00});

    // R1 tick enabled by reset mask, R5 full clear
    evt_set = 8'h01; step();
    chk(irq_n === 1'b0, "R1 tick raises irq", irq_n, 0);
    evt_set = 8'h02; step();
    ack_collect(0);
    chk_seq("R5 plain ack", '{8'h03});
    chk(irq_n === 1'b1, "R5 cleared irq", irq_n, 1);

    // R2 masked bit, R3 mask argc
    evt_set = 8'h02; step();
    chk(irq_n === 1'b1, "R2 masked bit no irq", irq_n, 1);
    cmd_mask_stb = 1; cmd_argc = 2; cmd_arg = 8'h02; step();
    chk(irq_n === 1'b1, "R3 argc 2 ignored", irq_n, 1);
    cmd_mask_stb = 1; cmd_argc = 0; cmd_arg = 8'h02; step();
    chk(irq_n === 1'b1, "R3 argc 0 ignored", irq_n, 1);
    cmd_mask_stb = 1; cmd_argc = 1; cmd_arg = 8'h02; step();
    chk(irq_n === 1'b0, "R3 mask loaded", irq_n, 0);

    // R4 ack with arguments rejected
    cmd_ack_stb = 1; cmd_argc = 1; step();
    chk(rsp_valid === 1'b0, "R4 no response", rsp_valid, 0);
    chk(irq_n === 1'b0, "R4 pending kept", irq_n, 0);
    ack_collect(0);
    chk_seq("R4 pending intact", '{8'h02});

    cmd_mask_stb = 1; cmd_argc = 1; cmd_arg = 8'h11; step();

    // R6 / R7 auto-poll with tick pending
    evt_set = 8'h01; step();
    load(1, 3, 8'hA1, 8'hA2, 8'hA3);
    ack_collect(0);
    chk_seq("R6 bus ack", '{8'h30, 8'hA1, 8'hA2, 8'hA3});
    chk(nlast == 1, "R11 one last flag", nlast, 1);
    chk(irq_n === 1'b0, "R6 tick survives", irq_n, 0);
    ack_collect(0);
    chk_seq("R6 remaining tick", '{8'h01});

    // R7 second auto-poll ignored
    load(1, 2, 8'hC1, 8'hC2, 8'h00);
    load(1, 3, 8'hD1, 8'hD2, 8'hD3);
    ack_collect(0);
    chk_seq("R7 second poll ignored", '{8'h30, 8'hC1, 8'hC2});

    // R8 non-auto reply replaces
    load(1, 1, 8'hE1, 8'h00, 8'h00);
    load(0, 2, 8'hB1, 8'hB2, 8'h00);
    ack_collect(0);
    chk_seq("R8 command reply", '{8'h30, 8'hB1, 8'hB2});
    load(0, 2, 8'hB5, 8'hB6, 8'h00);
    ack_collect(0);
    chk_seq("R8 bus bit only", '{8'h10, 8'hB5, 8'hB6});

    // R6 stored reply emptied
    evt_set = 8'h10; step();
    ack_collect(0);
    chk_seq("R6 reply emptied", '{8'h10});

    // R9 event wins over clear
    evt_set = 8'h01; step();
    ack_collect(8'h01);
    chk_seq("R9 collision ack", '{8'h01});
    chk(irq_n === 1'b0, "R9 bit kept", irq_n, 0);
    ack_collect(0);
    chk_seq("R9 kept bit read", '{8'h01});

    // R10 ack during stream ignored
    load(1, 3, 8'h71, 8'h72, 8'h73);
    cmd_ack_stb = 1; step();
    got.delete();
    got.push_back(rsp_data);
    cmd_ack_stb = 1; step();
    while (rsp_valid && got.size() < 20) begin
      got.push_back(rsp_data);
      step();
    end
    chk_seq("R10 stream untouched", '{8'h30, 8'h71, 8'h72, 8'h73});
    step();
    chk(rsp_valid === 1'b0, "R10 no second response", rsp_valid, 0);

    repeat (3) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule